// File: doc/BRIEF.md
# Port Change-Detect Interrupt Generator

This block watches a bank of general-purpose pins that have already been synchronized to the system clock. It raises one interrupt request whenever an input-direction pin no longer matches the level that was last latched for its port. Each port keeps a snapshot of its pins, and that snapshot is the value the register interface returns when software reads the port. A read-capture strobe from the register interface reloads the snapshot of one port. The strobe is timed to the acknowledge phase of the bus read.

The request is meant for an active-low, open-drain interrupt line. The block does not drive a level. It drives an enable that turns on the pull-down, and the line floats high while that enable is low. The interrupt clears in two ways: the pin goes back to its latched level, or software reads that pin's port. A read of one port never clears a change that is pending on another port. Pins set as outputs are masked out. If a pin is switched from output to input while its level differs from the snapshot, the request comes on at once.

Top module: `pcd_irq_top`

## Requirements
- R1: While reset is held, `irq_pull_o` is 0 (line released). On the first clock edge after reset is released, every port's snapshot loads the current pin levels, and `irq_pull_o` stays 0 for that cycle.
- R2: At the clock edge after a pin with a direction bit of 1 (input) differs from its snapshot bit, `irq_pull_o` becomes 1. It stays 1 for as long as the mismatch lasts and no capture happens.
- R3: At the clock edge after every input pin again matches its snapshot, `irq_pull_o` returns to 0, with no read needed.
- R4: When `cap_stb_i[p]` is high at a clock edge, the snapshot of port p (bits p*PORT_W and up, so port 0 sits in the low bits) loads that edge's pin levels. The result appears on `snap_o`, and that port's contribution to `irq_pull_o` clears at the same edge.
- R5: A capture strobe for one port neither changes the snapshot of another port nor clears a mismatch pending on another port.
- R6: A pin with a direction bit of 0 (output) never causes `irq_pull_o` to become 1, whatever its level.
- R7: When a pin's direction bit changes from 0 to 1 while its level differs from its snapshot, `irq_pull_o` becomes 1 at the next clock edge.
- R8: Strobes for several ports at the same edge capture all of those ports together.
- R9: With no capture strobe, a snapshot holds its value whatever the pins and direction bits do, and whether or not the pin is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PORTS*PORT_W | Synchronized pin levels; port p occupies bits [p*PORT_W +: PORT_W] |
| dir_i | input | NUM_PORTS*PORT_W | Direction per pin: 1 = input, 0 = output |
| cap_stb_i | input | NUM_PORTS | One-cycle read-capture strobe per port, issued at the read's acknowledge |
| irq_pull_o | output | 1 | Pull-down enable for the open-drain interrupt line (1 = line driven low) |
| snap_o | output | NUM_PORTS*PORT_W | Latched input snapshot per port, as returned by a register read |

## Verification
The bench builds the block with its defaults: two ports of eight pins each. Two ports are enough to show that a capture on one port leaves the other port alone, in both directions. With eight pins per port, single-bit changes can be placed at different positions in each port. The bench also covers strobes on both ports at the same edge, a capture at the same edge as a pin change, and a switch from output to input with a mismatched level.

// File: rtl/pcd_irq_pkg.sv
package pcd_irq_pkg;

    // Direction encoding carried on dir_i, one bit per pin.
    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } pin_dir_e;

    // Control state of the top: start-up load pending, registered request.
    typedef struct packed {
        logic init;
        logic irq;
    } irq_ctl_t;

endpackage

// File: rtl/pcd_snapshot.sv
module pcd_snapshot #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PORT_W-1:0] pin_i,
    output logic [PORT_W-1:0] snap_nxt_o,
    output logic [PORT_W-1:0] snap_o
);

    logic [PORT_W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (load_i) begin
            snap_d = pin_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign snap_nxt_o = snap_d;
    assign snap_o     = snap_q;

endmodule

// File: rtl/pcd_port_cmp.sv
module pcd_port_cmp
    import pcd_irq_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic [PORT_W-1:0] pin_i,
    input  logic [PORT_W-1:0] snap_i,
    input  logic [PORT_W-1:0] dir_i,
    output logic              hit_o
);

    logic [PORT_W-1:0] bit_hit;

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        always_comb begin
            bit_hit[b] = (pin_dir_e'(dir_i[b]) == DIR_IN) && (pin_i[b] != snap_i[b]);
        end
    end

    assign hit_o = |bit_hit;

endmodule

// File: rtl/pcd_irq_top.sv
module pcd_irq_top
    import pcd_irq_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_i,
    input  logic [NUM_PORTS*PORT_W-1:0] dir_i,
    input  logic [NUM_PORTS-1:0]        cap_stb_i,
    output logic                        irq_pull_o,
    output logic [NUM_PORTS*PORT_W-1:0] snap_o
);

    localparam int TOTAL_W = NUM_PORTS * PORT_W;

    irq_ctl_t              ctl_d, ctl_q;
    logic [TOTAL_W-1:0]    snap_nxt;
    logic [NUM_PORTS-1:0]  port_hit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pcd_snapshot #(.PORT_W(PORT_W)) u_snap (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (cap_stb_i[p] | ctl_q.init),
            .pin_i      (pin_i[p*PORT_W +: PORT_W]),
            .snap_nxt_o (snap_nxt[p*PORT_W +: PORT_W]),
            .snap_o     (snap_o[p*PORT_W +: PORT_W])
        );

        // Compare against the snapshot as it will stand after this edge,
        // so a capture clears its own port in the same cycle.
        pcd_port_cmp #(.PORT_W(PORT_W)) u_cmp (
            .pin_i  (pin_i[p*PORT_W +: PORT_W]),
            .snap_i (snap_nxt[p*PORT_W +: PORT_W]),
            .dir_i  (dir_i[p*PORT_W +: PORT_W]),
            .hit_o  (port_hit[p])
        );
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.init = 1'b0;
        ctl_d.irq  = !ctl_q.init && (|port_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{init: 1'b1, irq: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_pull_o = ctl_q.irq;

endmodule

// File: rtl/pcd_irq_chk.sv
module pcd_irq_chk #(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PORTS*PORT_W-1:0] pin_i,
    input logic [NUM_PORTS*PORT_W-1:0] dir_i,
    input logic [NUM_PORTS-1:0]        cap_stb_i,
    input logic                        irq_pull_o,
    input logic [NUM_PORTS*PORT_W-1:0] snap_o
);

    logic                        live_q;
    logic [NUM_PORTS*PORT_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assign diff = (pin_i ^ snap_o) & dir_i;

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_RELEASED: assert (!irq_pull_o); // R1
        end
    end

    AST_MISMATCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && (cap_stb_i == '0) && (diff != '0) |=> irq_pull_o); // R2

    AST_MATCH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && (cap_stb_i == '0) && (diff == '0) |=> !irq_pull_o); // R3

    AST_OUTPUTS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && (dir_i == '0) |=> !irq_pull_o); // R6

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            cap_stb_i[p] |=> snap_o[p*PORT_W +: PORT_W] == $past(pin_i[p*PORT_W +: PORT_W])); // R4

        AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && !cap_stb_i[p] |=> $stable(snap_o[p*PORT_W +: PORT_W])); // R9

        AST_OTHER_PORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            live_q && !cap_stb_i[p] && (diff[p*PORT_W +: PORT_W] != '0) |=> irq_pull_o); // R5
    end

endmodule

bind pcd_irq_top pcd_irq_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) chk_i (.*);

// File: tb/pcd_irq_top_tb_top.sv
module pcd_irq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [15:0]   pin;
    logic [15:0]   dir;
    logic [1:0]    cap;
    logic          irq;
    logic [15:0]   snap;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcd_irq_top #(.NUM_PORTS(NP), .PORT_W(PW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin),
        .dir_i      (dir),
        .cap_stb_i  (cap),
        .irq_pull_o (irq),
        .snap_o     (snap)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One rising edge, then return to the falling edge for sampling/driving.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe(input logic [1:0] which);
        cap = which;
        step();
        cap = 2'b00;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pin = 16'hA5C3; dir = 16'hFFFF; cap = 2'b00;
        step(); step();
        chk("R1 irq in reset", {15'd0, irq}, 16'h0000);
        rst_n = 1'b1;
        step();
        chk("R1 snapshot loaded", snap, 16'hA5C3);
        chk("R1 irq after release", {15'd0, irq}, 16'h0000);
        step();
        chk("R3 idle match", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_change_and_return();
        pin = 16'hA5CB;
        step();
        chk("R2 input change", {15'd0, irq}, 16'h0001);
        step();
        chk("R2 persists", {15'd0, irq}, 16'h0001);
        chk("R9 snapshot held", snap, 16'hA5C3);
        pin = 16'hA5C3;
        step();
        chk("R3 returned", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_read_clears();
        pin = 16'hB5C3;
        step();
        chk("R2 port1 change", {15'd0, irq}, 16'h0001);
        strobe(2'b10);
        chk("R4 port1 captured", snap, 16'hB5C3);
        chk("R4 read clears", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_isolation();
        pin = 16'hB4C2;
        step();
        chk("R2 both ports", {15'd0, irq}, 16'h0001);
        strobe(2'b01);
        chk("R5 port0 read keeps port1 snap", snap, 16'hB5C2);
        chk("R5 port1 still pending", {15'd0, irq}, 16'h0001);
        strobe(2'b10);
        chk("R4 port1 read", snap, 16'hB4C2);
        chk("R4 all clear", {15'd0, irq}, 16'h0000);
        pin = 16'hB4C3;
        step();
        chk("R2 port0 again", {15'd0, irq}, 16'h0001);
        strobe(2'b10);
        chk("R5 port1 read keeps port0 pending", {15'd0, irq}, 16'h0001);
        chk("R5 port0 snap untouched", snap, 16'hB4C2);
        strobe(2'b01);
        chk("R4 port0 read clears", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_outputs_and_switch();
        dir = 16'h0000;
        pin = 16'h0000;
        step();
        chk("R6 outputs silent", {15'd0, irq}, 16'h0000);
        pin = 16'h5A5A;
        step(); step();
        chk("R6 outputs toggling", {15'd0, irq}, 16'h0000);
        chk("R9 snap held with outputs", snap, 16'hB4C3);
        pin = 16'h0000;
        dir = 16'h0001;
        step();
        chk("R7 out->in mismatch", {15'd0, irq}, 16'h0001);
        dir = 16'h0000;
        step();
        chk("R6 back to output", {15'd0, irq}, 16'h0000);
        pin = 16'hB4C3;
        dir = 16'h0100;
        step();
        chk("R7 out->in matching level", {15'd0, irq}, 16'h0000);
        dir = 16'hFFFF;
        step();
        chk("R3 all inputs matching", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_dual_and_same_edge();
        pin = 16'h1234;
        strobe(2'b11);
        chk("R8 dual capture", snap, 16'h1234);
        chk("R8 no irq after dual", {15'd0, irq}, 16'h0000);
        pin = 16'h1235;
        strobe(2'b01);
        chk("R4 same-edge capture", snap, 16'h1235);
        chk("R4 same-edge no irq", {15'd0, irq}, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_change_and_return();
        t_read_clears();
        t_isolation();
        t_outputs_and_switch();
        t_dual_and_same_edge();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule